// File: doc/BRIEF.md
# Parallel FPGA Configuration Host Sequencer

This block sits on the host side of a passive parallel configuration link and loads a target FPGA. It runs the target's reset handshake. It pulls the configuration-request line low for a minimum time, checks that the target has answered by dropping its status and done lines, and releases the request. It then waits for the status line to come back high, observes a settling delay, and starts clocking words in. The configuration words arrive on a valid/ready stream that is 8, 16 or 32 bits wide. Each word is held on the data pins across N rising edges of the configuration clock. A new word is accepted only once the previous one has finished its N edges.

After the last word, the sequencer keeps toggling the configuration clock until the target raises its done line. It gives up after a set number of edges. Once done is seen, it waits a fixed user-mode entry time and then asserts its own done output. Every failure ends in an error state that carries a code. A fresh start pulse from the done or error state begins a new configuration cycle.

All delays are given in microseconds and converted to system-clock cycles using a clock-frequency parameter. A parameter selects whether the status line is monitored. When it is not monitored, a single long wait after release replaces the handshake.

Top module: `fpga_cfg_host`

## Requirements
- R1: Out of reset, tgt_cfg_n is 1, tgt_dclk is 0, done is 0, err_code is 0 and s_ready is 0.
- R2: A start pulse drives tgt_cfg_n low for exactly T_LOW_US×CLK_MHZ system cycles.
- R3: If tgt_conf_done is high at the end of the low pulse (or tgt_status_n is high, when monitored), err_code becomes 1 (stuck) and tgt_cfg_n returns high without any tgt_dclk edge.
- R4: If tgt_status_n stays low after release, err_code becomes 2 (status timeout) exactly T_STO_US×CLK_MHZ cycles after tgt_cfg_n rises.
- R5: With monitoring on, the first rising tgt_dclk edge comes no sooner than T_ST2CK_US×CLK_MHZ cycles after tgt_status_n rises, and no more than 15 cycles beyond that.
- R6: Each accepted word appears on tgt_data for exactly N consecutive rising tgt_dclk edges, in stream order. tgt_data never changes while tgt_dclk is high. Every high phase of tgt_dclk lasts DIV system cycles.
- R7: s_ready is high only between words, with tgt_dclk low. While the stream stalls, tgt_dclk stays low.
- R8: After the word flagged by s_last, tgt_dclk keeps running. If tgt_conf_done does not rise within FLUSH_MAX further rising edges, the block stops after exactly FLUSH_MAX edges with err_code 4 (done timeout).
- R9: With monitoring on, tgt_status_n falling during transfer or flush sets err_code 3 (status lost). tgt_dclk then stays low with no further rising edge.
- R10: done rises between T_UM_US×CLK_MHZ and that value plus 8 cycles after tgt_conf_done rises, and never before tgt_conf_done is high.
- R11: A start pulse in the done or error state clears err_code to 0 on the next cycle and begins a new low pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a configuration cycle (idle, done or error state) |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted this cycle when valid |
| s_data | input | W | Stream configuration word |
| s_last | input | 1 | Marks the final word of the bitstream |
| tgt_cfg_n | output | 1 | Configuration request to target, active low |
| tgt_dclk | output | 1 | Configuration clock to target |
| tgt_data | output | W | Configuration data to target |
| tgt_status_n | input | 1 | Target status line, low while resetting or on error |
| tgt_conf_done | input | 1 | Target done line |
| done | output | 1 | Target has been given its user-mode entry time |
| err_code | output | 3 | 0 none, 1 stuck, 2 status timeout, 3 status lost, 4 done timeout |

## Verification
The hardest situation to reach from the ports is losing the status line partway through a word, while the clock may be high and the stream may be stalled. The bench's target model can pull its status line low once a chosen number of edges has been captured. That places the failure in the middle of the third word, after which the bench confirms that no further edge appears. The flush timeout is reached the same way: the model never raises done, and the bench counts every captured edge to confirm the exact total.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PULL, ST_WSTAT, ST_PRECK, ST_XFER,
    ST_FLUSH, ST_USER, ST_DONE, ST_ERR
  } cfg_state_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_STUCK     = 3'd1,
    E_STAT_TO   = 3'd2,
    E_STAT_LOST = 3'd3,
    E_DONE_TO   = 3'd4
  } cfg_err_e;

  // microseconds to system cycles, never below one cycle
  function automatic int us_to_cyc(input int us, input int mhz);
    int c;
    c = us * mhz;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          active;
  logic          tick;

  // a high phase always completes even after run drops
  assign active = run || dclk;
  assign tick   = active && (cnt == '0);
  assign rise   = tick && !dclk;
  assign fall   = tick && dclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= CW'(DIV - 1);
      dclk <= 1'b0;
    end else begin
      if (!active || tick) cnt <= CW'(DIV - 1);
      else                 cnt <= cnt - 1'b1;
      if (tick) dclk <= ~dclk;
    end
  end

  int hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_len <= 0;
    else        hi_len <= dclk ? hi_len + 1 : 0;
  end

  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk) |-> hi_len == DIV); // R6
endmodule

// File: rtl/fpga_cfg_host.sv
module fpga_cfg_host
  import cfg_host_pkg::*;
#(
  parameter int W          = 8,
  parameter int N          = 2,
  parameter int DIV        = 2,
  parameter int CLK_MHZ    = 125,
  parameter bit MON_STATUS = 1'b1,
  parameter int T_LOW_US   = 2,
  parameter int T_STO_US   = 3000,
  parameter int T_ST2CK_US = 10,
  parameter int T_CF2CK_US = 3010,
  parameter int T_UM_US    = 200,
  parameter int FLUSH_MAX  = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         s_last,
  output logic         tgt_cfg_n,
  output logic         tgt_dclk,
  output logic [W-1:0] tgt_data,
  input  logic         tgt_status_n,
  input  logic         tgt_conf_done,
  output logic         done,
  output logic [2:0]   err_code
);
  localparam int L_LOW   = us_to_cyc(T_LOW_US, CLK_MHZ);
  localparam int L_STO   = us_to_cyc(T_STO_US, CLK_MHZ);
  localparam int L_ST2CK = us_to_cyc(T_ST2CK_US, CLK_MHZ);
  localparam int L_CF2CK = us_to_cyc(T_CF2CK_US, CLK_MHZ);
  localparam int L_UM    = us_to_cyc(T_UM_US, CLK_MHZ);
  localparam int MAXV    = max_of(max_of(L_LOW, L_STO),
                                  max_of(max_of(L_ST2CK, L_CF2CK), L_UM));
  localparam int TW      = $clog2(MAXV + 1);
  localparam int BW      = $clog2(N + 1);
  localparam int FW      = $clog2(FLUSH_MAX + 1);

  cfg_state_e     state, state_d;
  cfg_err_e       err_q, err_val;
  logic           err_set, restart;
  logic           tmr_load, tmr_exp;
  logic [TW-1:0]  tmr_val;
  logic           st_ok_s, cd_s;
  logic           run, rise, fall;
  logic [W-1:0]   data_q;
  logic           last_q, have, accept, word_end, lost;
  logic [BW-1:0]  beat;
  logic [FW-1:0]  fcnt;

  cfg_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({tgt_status_n, tgt_conf_done}), .q({st_ok_s, cd_s}));

  cfg_delay_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp));

  cfg_dclk_gen #(.DIV(DIV)) u_dclk (
    .clk(clk), .rst_n(rst_n), .run(run), .dclk(tgt_dclk), .rise(rise), .fall(fall));

  // named events shared by the sequencer and the assertions
  assign restart  = start && (state == ST_IDLE || state == ST_DONE || state == ST_ERR);
  assign accept   = s_valid && s_ready;
  assign word_end = (state == ST_XFER) && have && fall && (beat == BW'(N));
  assign lost     = MON_STATUS && !st_ok_s;
  assign run      = ((state == ST_XFER) && have) || (state == ST_FLUSH);
  assign s_ready  = (state == ST_XFER) && !have;

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    err_set  = 1'b0;
    err_val  = E_NONE;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERR:
        if (start) begin
          state_d = ST_PULL; tmr_load = 1'b1; tmr_val = TW'(L_LOW - 1);
        end
      ST_PULL:
        if (tmr_exp) begin
          if (cd_s || (MON_STATUS && st_ok_s)) begin
            state_d = ST_ERR; err_set = 1'b1; err_val = E_STUCK;
          end else if (MON_STATUS) begin
            state_d = ST_WSTAT; tmr_load = 1'b1; tmr_val = TW'(L_STO - 1);
          end else begin
            state_d = ST_PRECK; tmr_load = 1'b1; tmr_val = TW'(L_CF2CK - 1);
          end
        end
      ST_WSTAT:
        if (st_ok_s) begin
          state_d = ST_PRECK; tmr_load = 1'b1; tmr_val = TW'(L_ST2CK - 1);
        end else if (tmr_exp) begin
          state_d = ST_ERR; err_set = 1'b1; err_val = E_STAT_TO;
        end
      ST_PRECK:
        if (lost) begin
          state_d = ST_ERR; err_set = 1'b1; err_val = E_STAT_LOST;
        end else if (tmr_exp) begin
          state_d = ST_XFER;
        end
      ST_XFER:
        if (lost) begin
          state_d = ST_ERR; err_set = 1'b1; err_val = E_STAT_LOST;
        end else if (word_end && last_q) begin
          state_d = ST_FLUSH;
        end
      ST_FLUSH:
        if (lost) begin
          state_d = ST_ERR; err_set = 1'b1; err_val = E_STAT_LOST;
        end else if (cd_s) begin
          state_d = ST_USER; tmr_load = 1'b1; tmr_val = TW'(L_UM - 1);
        end else if (rise && fcnt == FW'(FLUSH_MAX - 1)) begin
          state_d = ST_ERR; err_set = 1'b1; err_val = E_DONE_TO;
        end
      ST_USER:
        if (tmr_exp) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      err_q  <= E_NONE;
      data_q <= '0;
      last_q <= 1'b0;
      have   <= 1'b0;
      beat   <= '0;
      fcnt   <= '0;
    end else begin
      state <= state_d;
      if (err_set)      err_q <= err_val;
      else if (restart) err_q <= E_NONE;
      if (accept) begin
        data_q <= s_data;
        last_q <= s_last;
        have   <= 1'b1;
        beat   <= '0;
      end else if (state == ST_XFER && have) begin
        if (rise)     beat <= beat + 1'b1;
        if (word_end) have <= 1'b0;
      end else if (state != ST_XFER) begin
        have <= 1'b0;
      end
      if (state != ST_FLUSH) fcnt <= '0;
      else if (rise)         fcnt <= fcnt + 1'b1;
    end
  end

  assign tgt_cfg_n = (state != ST_PULL);
  assign tgt_data  = data_q;
  assign done      = (state == ST_DONE);
  assign err_code  = err_q;

  int low_len;
  always_ff @(posedge clk) begin
    if (!rst_n) low_len <= 0;
    else        low_len <= tgt_cfg_n ? 0 : low_len + 1;
  end

  AST_CFG_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_cfg_n) |-> low_len >= L_LOW); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_dclk |-> $stable(tgt_data)); // R6
  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !tgt_dclk); // R7
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERR && !tgt_dclk) |=> !tgt_dclk); // R9
  AST_DONE_AFTER_CD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cd_s); // R10
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> err_code == 3'd0); // R11
endmodule

// File: tb/sim_fpga_cfg_host.sv
module sim_fpga_cfg_host;
  localparam int W = 8, N = 3, DIV = 2, FMAX = 16, MHZ = 125;
  localparam int LOW_US = 1, STO_US = 40, ST2CK_US = 1, UM_US = 2;
  localparam int L_LOW = LOW_US * MHZ;
  localparam int L_STO = STO_US * MHZ;
  localparam int L_ST2CK = ST2CK_US * MHZ;
  localparam int L_UM = UM_US * MHZ;

  logic clk = 1'b0;
  logic rst_n, start, s_valid, s_last;
  logic [W-1:0] s_data;
  logic s_ready, tgt_cfg_n, tgt_dclk, done;
  logic [W-1:0] tgt_data;
  logic [2:0] err_code;
  logic st_n = 1'b0, cd = 1'b0;

  always #4 clk = ~clk;

  fpga_cfg_host #(
    .W(W), .N(N), .DIV(DIV), .CLK_MHZ(MHZ), .MON_STATUS(1'b1),
    .T_LOW_US(LOW_US), .T_STO_US(STO_US), .T_ST2CK_US(ST2CK_US),
    .T_CF2CK_US(30), .T_UM_US(UM_US), .FLUSH_MAX(FMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .tgt_cfg_n(tgt_cfg_n), .tgt_dclk(tgt_dclk),
    .tgt_data(tgt_data), .tgt_status_n(st_n), .tgt_conf_done(cd),
    .done(done), .err_code(err_code));

  // target model
  logic mdl_hang = 0, mdl_stuck = 0, mdl_drop = 0, mdl_cd_en = 0;
  int mdl_cd_after = 0;
  int cyc = 0, rises = 0, t_st = 0, t_cd = 0, st_dly = 0;
  logic dclk_q = 0;
  logic [W-1:0] cap [0:255];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    dclk_q <= tgt_dclk;
    if (tgt_dclk && !dclk_q) begin
      cap[rises[7:0]] <= tgt_data;
      rises <= rises + 1;
    end
    if (mdl_drop) st_n <= 1'b0;
    else if (!tgt_cfg_n) begin st_n <= 1'b0; st_dly <= 0; end
    else if (!st_n && !mdl_hang) begin
      if (st_dly == 20) begin st_n <= 1'b1; t_st <= cyc; end
      else st_dly <= st_dly + 1;
    end
    if (!tgt_cfg_n) cd <= mdl_stuck;
    else if (mdl_cd_en && !cd && rises >= mdl_cd_after) begin cd <= 1'b1; t_cd <= cyc; end
  end

  // port monitor
  int low_run = 0, last_low = 0, hi_run = 0, hi_bad = 0, rdy_bad = 0;
  always @(negedge clk) begin
    if (!tgt_cfg_n) low_run++;
    else if (low_run != 0) begin last_low = low_run; low_run = 0; end
    if (tgt_dclk) hi_run++;
    else if (hi_run != 0) begin if (hi_run != DIV) hi_bad++; hi_run = 0; end
    if (s_ready && tgt_dclk) rdy_bad++;
  end

  int total = 0, bad = 0;
  logic fin = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(i * 37 + 11);
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_word(input logic [W-1:0] d, input logic last);
    s_valid = 1'b1; s_data = d; s_last = last;
    while (!s_ready && err_code == 3'd0) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_stream(input int first, input int n);
    for (int i = first; i < n; i++) begin
      send_word(pat(i), i == n - 1);
      if (err_code != 3'd0) break;
      repeat (i % 3) @(negedge clk);
    end
  endtask

  task automatic wait_outcome(input int limit);
    for (int k = 0; k < limit; k++) begin
      if (done || err_code != 3'd0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int r0, ra, t_first, t0, mism;
    rst_n = 0; start = 0; s_valid = 0; s_last = 0; s_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "cfg_n", tgt_cfg_n, 1);
    chk("R1", "dclk", tgt_dclk, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err_code, 0);
    chk("R1", "ready", s_ready, 0);

    // normal load of 12 words
    r0 = rises; mdl_cd_en = 1; mdl_cd_after = r0 + 12 * N + 3;
    t_first = 0;
    pulse_start();
    fork
      begin
        while (rises == r0) @(negedge clk);
        t_first = cyc;
      end
      send_stream(0, 12);
    join
    chk("R2", "low pulse length", last_low, L_LOW);
    chk_rng("R5", "status-high to first edge", t_first - t_st, L_ST2CK, L_ST2CK + 15);
    wait_outcome(3000);
    chk("R10", "done set", done, 1);
    chk("R10", "err after success", err_code, 0);
    chk_rng("R10", "conf_done to done", cyc - t_cd, L_UM, L_UM + 8);
    for (int i = 0; i < 12; i++) begin
      mism = 0;
      for (int b = 0; b < N; b++)
        if (cap[(r0 + i * N + b) & 255] !== pat(i)) mism++;
      chk("R6", $sformatf("word %0d edges with wrong data", i), mism, 0);
    end
    chk("R6", "high phases not DIV long", hi_bad, 0);
    chk("R7", "ready while dclk high", rdy_bad, 0);

    // flush timeout, restart from done, stream stall
    r0 = rises; mdl_cd_en = 0;
    pulse_start();
    chk("R11", "err after restart from done", err_code, 0);
    chk("R11", "cfg_n low after restart", tgt_cfg_n, 0);
    send_word(pat(0), 1'b0);
    repeat (20) @(negedge clk);
    ra = rises;
    repeat (15) @(negedge clk);
    chk("R7", "edges during stall", rises - ra, 0);
    chk("R7", "dclk during stall", tgt_dclk, 0);
    send_stream(1, 6);
    wait_outcome(3000);
    repeat (10) @(negedge clk);
    chk("R8", "err code", err_code, 4);
    chk("R8", "total edges", rises - r0, 6 * N + FMAX);

    // status lost mid-transfer, restart from error
    r0 = rises;
    pulse_start();
    chk("R11", "err after restart from error", err_code, 0);
    fork
      send_stream(0, 10);
      begin
        while (rises < r0 + 7) @(negedge clk);
        mdl_drop = 1;
      end
    join
    wait_outcome(200);
    repeat (3) @(negedge clk);
    chk("R9", "err code", err_code, 3);
    ra = rises;
    repeat (40) @(negedge clk);
    chk("R9", "edges after loss", rises - ra, 0);
    chk("R9", "dclk parked", tgt_dclk, 0);
    mdl_drop = 0;

    // status never returns
    mdl_hang = 1;
    pulse_start();
    while (!tgt_cfg_n) @(negedge clk);
    t0 = cyc;
    while (cyc < t0 + L_STO - 2) @(negedge clk);
    chk("R4", "err before timeout", err_code, 0);
    while (cyc < t0 + L_STO + 1) @(negedge clk);
    chk("R4", "err at timeout", err_code, 2);
    mdl_hang = 0;

    // done line stuck high
    mdl_stuck = 1; r0 = rises;
    pulse_start();
    repeat (L_LOW + 6) @(negedge clk);
    chk("R3", "err code", err_code, 1);
    chk("R3", "cfg_n released", tgt_cfg_n, 1);
    chk("R3", "edges", rises - r0, 0);
    mdl_stuck = 0;

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule